// File: doc/BRIEF.md
# Non-Restoring Sequential Divider

This block divides an unsigned double-width dividend by a single-width divisor and produces one quotient bit per clock. The operand width is 8, 16 or 32 bits and is chosen per operation. The dividend is given as two halves, an upper part and a lower part, each as wide as the chosen operand width. The divisor has the same width. When the operation ends the block returns the quotient and the remainder, and it raises a one-cycle completion strobe.

Each loop step shifts the partial remainder and the dividend low bits left by one. The step then adds or subtracts the divisor depending on the sign of the partial remainder, and it keeps the inverted sign of the result as the next quotient bit. The loop always runs exactly as many steps as the operand width. A single correction step follows the loop and adds the divisor back when the final partial remainder is negative. Two set-up cycles and two output cycles make the latency a fixed operand width plus six.

The block rejects operations whose quotient would not fit the operand width. These are a zero divisor and an upper dividend half that is not smaller than the divisor. It reports such an operation with an error flag and does not iterate.

Top module: `seqDivider`

## Requirements
- R1: `widthSel` selects the operand width W: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32. Only bits [W-1:0] of `dividendHi`, `dividendLo` and `divisor` are used. Higher bits have no effect on any output.
- R2: For a valid operation, `quotient` equals floor(({hi,lo}) / divisor) and `remainder` equals ({hi,lo}) mod divisor. Here {hi,lo} is the 2W-bit value with the masked upper half in the high bits. Both outputs are zero-extended to 32 bits.
- R3: A `start` seen high at a clock edge while idle begins an operation. For a valid operation, `done` is high right after the (W+6)-th rising edge, counting the start edge as the first. That is a latency of 14, 22 or 38 cycles.
- R4: `done` is high for exactly one cycle per operation. `quotient`, `remainder` and `error` change only in the cycle where `done` is high, and they hold their values until the next completion.
- R5: A masked divisor of zero completes with `done` right after the second edge, counting the start edge as the first. It sets `error` to 1 and sets `quotient` and `remainder` to 0.
- R6: A masked upper dividend half greater than or equal to the masked divisor also completes as in R5, with `error` 1 and zero results. A valid operation sets `error` to 0.
- R7: `start` is ignored while an operation is in progress. The edge on which `done` rises leaves the block idle, so a `start` at the very next edge is accepted.
- R8: While `rstN` is low, `done`, `error`, `quotient` and `remainder` are all 0.
- R9: `widthSel` 2'b11 behaves identically to 2'b10, in both results and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| widthSel | input | 2 | Operand width code |
| dividendHi | input | 32 | Upper half of the dividend |
| dividendLo | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| quotient | output | 32 | Quotient, zero-extended |
| remainder | output | 32 | Remainder, zero-extended |
| done | output | 1 | One-cycle completion strobe |
| error | output | 1 | Rejected operation flag |

## Verification
Most internal faults in this divider stay hidden until the completion strobe. Examples are a wrong add-or-subtract choice, a dividend bit shifted in from the wrong position, or a skipped correction step. Each of these shows up as a wrong quotient or remainder in the single cycle where `done` is high. A loop counter that is off by one moves that strobe a cycle early or late, so comparing `done` on every clock catches it at once. A faulty operand check shows up two cycles after `start` as a missing or a false error completion. Operands are chosen near the quotient-overflow boundary, with junk in the unused upper bits, and with back-to-back starts, so that each of these faults reaches the ports.

// File: rtl/divPkg.sv
package divPkg;

  localparam int unsigned PRE_CYCLES  = 2;
  localparam int unsigned POST_CYCLES = 2;

  typedef struct packed {
    logic capture;
    logic align;
    logic step;
    logic fix;
    logic finish;
  } divStrobe_t;

  function automatic int unsigned opWidth(input logic [1:0] sel, input int unsigned maxW);
    case (sel)
      2'b00:   return maxW / 4;
      2'b01:   return maxW / 2;
      default: return maxW;
    endcase
  endfunction

endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int unsigned MAXW = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] widthSel,
  input  logic       badOperand,
  output divStrobe_t strobe,
  output logic       done
);

  localparam int unsigned CNTW   = $clog2(MAXW);
  localparam int unsigned PHMAX  = (PRE_CYCLES > POST_CYCLES) ? PRE_CYCLES : POST_CYCLES;
  localparam int unsigned PHW    = $clog2(PHMAX) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_LOOP, ST_FIX, ST_POST} state_t;

  state_t          state;
  logic [PHW-1:0]  phase;
  logic [CNTW-1:0] loopCnt;
  logic [1:0]      widthQ;

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.capture = start;
      ST_PRE: begin
        if (phase == '0 && badOperand)                 strobe.finish = 1'b1;
        else if (phase == PHW'(PRE_CYCLES - 1))        strobe.align  = 1'b1;
      end
      ST_LOOP: strobe.step = 1'b1;
      ST_FIX:  strobe.fix  = 1'b1;
      ST_POST: if (phase == PHW'(POST_CYCLES - 1))     strobe.finish = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      loopCnt <= '0;
      widthQ  <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_PRE;
          phase  <= '0;
          widthQ <= widthSel;
        end
        ST_PRE: begin
          if (strobe.finish) begin
            state <= ST_IDLE;
          end else if (strobe.align) begin
            state   <= ST_LOOP;
            loopCnt <= CNTW'(opWidth(widthQ, MAXW) - 1);
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_LOOP: begin
          if (loopCnt == '0) state <= ST_FIX;
          else               loopCnt <= loopCnt - 1'b1;
        end
        ST_FIX: begin
          state <= ST_POST;
          phase <= '0;
        end
        ST_POST: begin
          if (strobe.finish) state <= ST_IDLE;
          else               phase <= phase + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int unsigned MAXW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  divStrobe_t      strobe,
  input  logic [1:0]      widthSel,
  input  logic [MAXW-1:0] dividendHi,
  input  logic [MAXW-1:0] dividendLo,
  input  logic [MAXW-1:0] divisor,
  output logic            badOperand,
  output logic [MAXW-1:0] quotient,
  output logic [MAXW-1:0] remainder,
  output logic            error
);

  localparam int unsigned REMW = MAXW + 2;

  logic [1:0]      widthQ;
  logic [MAXW-1:0] hiQ, loQ, dvQ;
  logic [MAXW-1:0] opMask, hiM, loM, dvM;
  logic [REMW-1:0] remReg, dvExt, shifted, nextRem;
  logic [MAXW-1:0] loReg, quoReg;
  int unsigned     opW;

  always_comb begin
    opW        = opWidth(widthQ, MAXW);
    opMask     = {MAXW{1'b1}} >> (MAXW - opW);
    hiM        = hiQ & opMask;
    loM        = loQ & opMask;
    dvM        = dvQ & opMask;
    badOperand = (dvM == '0) || (hiM >= dvM);
    dvExt      = {2'b00, dvM};
    shifted    = {remReg[REMW-2:0], loReg[MAXW-1]};
    nextRem    = remReg[REMW-1] ? shifted + dvExt : shifted - dvExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ    <= '0;
      hiQ       <= '0;
      loQ       <= '0;
      dvQ       <= '0;
      remReg    <= '0;
      loReg     <= '0;
      quoReg    <= '0;
      quotient  <= '0;
      remainder <= '0;
      error     <= 1'b0;
    end else begin
      if (strobe.capture) begin
        widthQ <= widthSel;
        hiQ    <= dividendHi;
        loQ    <= dividendLo;
        dvQ    <= divisor;
      end
      if (strobe.align) begin
        remReg <= {2'b00, hiM};
        loReg  <= loM << (MAXW - opW);
        quoReg <= '0;
      end
      if (strobe.step) begin
        remReg <= nextRem;
        loReg  <= loReg << 1;
        quoReg <= {quoReg[MAXW-2:0], ~nextRem[REMW-1]};
      end
      if (strobe.fix && remReg[REMW-1]) begin
        remReg <= remReg + dvExt;
      end
      if (strobe.finish) begin
        if (badOperand) begin
          quotient  <= '0;
          remainder <= '0;
          error     <= 1'b1;
        end else begin
          quotient  <= quoReg & opMask;
          remainder <= remReg[MAXW-1:0] & opMask;
          error     <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int unsigned MAXW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      widthSel,
  input  logic [MAXW-1:0] dividendHi,
  input  logic [MAXW-1:0] dividendLo,
  input  logic [MAXW-1:0] divisor,
  output logic [MAXW-1:0] quotient,
  output logic [MAXW-1:0] remainder,
  output logic            done,
  output logic            error
);

  divStrobe_t strobe;
  logic       badOperand;

  divControl #(.MAXW(MAXW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .widthSel   (widthSel),
    .badOperand (badOperand),
    .strobe     (strobe),
    .done       (done)
  );

  divDatapath #(.MAXW(MAXW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .widthSel   (widthSel),
    .dividendHi (dividendHi),
    .dividendLo (dividendLo),
    .divisor    (divisor),
    .badOperand (badOperand),
    .quotient   (quotient),
    .remainder  (remainder),
    .error      (error)
  );

endmodule

// File: rtl/seqDividerChecker.sv
module seqDividerChecker
  import divPkg::*;
#(
  parameter int unsigned MAXW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [1:0]      widthSel,
  input logic [MAXW-1:0] dividendHi,
  input logic [MAXW-1:0] dividendLo,
  input logic [MAXW-1:0] divisor,
  input logic [MAXW-1:0] quotient,
  input logic [MAXW-1:0] remainder,
  input logic            done,
  input logic            error
);

  logic            ckBusy;
  int unsigned     ckLat;
  logic [1:0]      ckSel;
  logic [MAXW-1:0] ckHi, ckLo, ckDv;
  int unsigned     ckW;
  logic [MAXW-1:0] ckMask, ckDvM;
  logic [2*MAXW-1:0] ckDividend, ckRebuilt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckBusy <= 1'b0;
      ckLat  <= 0;
      ckSel  <= '0;
      ckHi   <= '0;
      ckLo   <= '0;
      ckDv   <= '0;
    end else if (ckBusy && !done) begin
      ckLat <= ckLat + 1;
    end else if (start) begin
      ckBusy <= 1'b1;
      ckLat  <= 1;
      ckSel  <= widthSel;
      ckHi   <= dividendHi;
      ckLo   <= dividendLo;
      ckDv   <= divisor;
    end else begin
      ckBusy <= 1'b0;
    end
  end

  always_comb begin
    ckW        = opWidth(ckSel, MAXW);
    ckMask     = {MAXW{1'b1}} >> (MAXW - ckW);
    ckDvM      = ckDv & ckMask;
    ckDividend = ({{MAXW{1'b0}}, ckHi & ckMask} << ckW) | {{MAXW{1'b0}}, ckLo & ckMask};
    ckRebuilt  = {{MAXW{1'b0}}, quotient} * {{MAXW{1'b0}}, ckDvM} + {{MAXW{1'b0}}, remainder};
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  p_hold_r4:       assert property (@(posedge clk) disable iff (!rstN)
                     !done |-> $stable(quotient) && $stable(remainder) && $stable(error));
  p_done_owned_r7: assert property (@(posedge clk) disable iff (!rstN) done |-> ckBusy);
  p_latency_r3:    assert property (@(posedge clk) disable iff (!rstN)
                     done && !error |-> ckLat == ckW + 6);
  // R5 and R6: rejected operations finish fast with zero results
  p_err_fast_r5:   assert property (@(posedge clk) disable iff (!rstN)
                     done && error |-> ckLat == 2 && quotient == '0 && remainder == '0);
  p_err_cause_r6:  assert property (@(posedge clk) disable iff (!rstN)
                     done |-> error == ((ckDvM == '0) || ((ckHi & ckMask) >= ckDvM)));
  p_rem_below_r2:  assert property (@(posedge clk) disable iff (!rstN)
                     done && !error |-> remainder < ckDvM);
  p_identity_r2:   assert property (@(posedge clk) disable iff (!rstN)
                     done && !error |-> ckRebuilt == ckDividend);

endmodule

bind seqDivider seqDividerChecker #(.MAXW(MAXW)) u_chk (.*);

// File: tb/seqDivider_tb.sv
module seqDivider_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  widthSel = 2'b00;
  logic [31:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic [31:0] quotient, remainder;
  logic        done, error;

  seqDivider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .widthSel(widthSel),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .error(error)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    finished = 0;

  // behavioural reference model
  bit          mBusy = 0, mDone = 0, mErr = 0, pendE = 0;
  int          mCnt = 0;
  logic [31:0] mQ = '0, mR = '0, pendQ = '0, pendR = '0;
  string       curTag = "R2", pendTag = "R2", outTag = "R8";

  function automatic int widthOfSel(logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mErr = 0; mQ = '0; mR = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt--;
        if (mCnt == 0) begin
          mBusy = 0; mDone = 1; mQ = pendQ; mR = pendR; mErr = pendE; outTag = pendTag;
        end
      end else if (start) begin
        int w;
        logic [31:0] msk, h, l, d;
        longint unsigned dd;
        w   = widthOfSel(widthSel);
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        h = dividendHi & msk; l = dividendLo & msk; d = divisor & msk;
        pendE = (d == 0) || (h >= d);
        if (pendE) begin
          pendQ = '0; pendR = '0; mCnt = 1;
        end else begin
          dd = (longint'(h) << w) | longint'(l);
          pendQ = 32'(dd / longint'(d));
          pendR = 32'(dd % longint'(d));
          mCnt = w + 5;
        end
        pendTag = curTag;
        mBusy = 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 latency / R4 single pulse: done", {31'b0, done}, {31'b0, mDone});
      chk({outTag, " error"},     {31'b0, error}, {31'b0, mErr});
      chk({outTag, " quotient"},  quotient, mQ);
      chk({outTag, " remainder"}, remainder, mR);
    end
  end

  task automatic report();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      $display("FAIL R3 watchdog actual hung expected done");
      report();
    end
  end

  // called at a negedge; returns at the negedge after completion
  task automatic runOp(logic [1:0] ws, logic [31:0] hi, logic [31:0] lo, logic [31:0] dv, string tag);
    widthSel = ws; dividendHi = hi; dividendLo = lo; divisor = dv; curTag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mBusy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset done",      {31'b0, done}, 32'd0);
    chk("R8 reset error",     {31'b0, error}, 32'd0);
    chk("R8 reset quotient",  quotient, 32'd0);
    chk("R8 reset remainder", remainder, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(2'b00, 32'h12, 32'h34, 32'h56, "R2 8-bit");
    runOp(2'b01, 32'h1234, 32'hABCD, 32'h8001, "R2 16-bit");
    runOp(2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 32-bit");
    runOp(2'b10, 32'h0, 32'hDEAD_BEEF, 32'h1, "R2 divide by one");
    runOp(2'b00, 32'hFE, 32'hFF, 32'hFF, "R6 boundary below");
    runOp(2'b00, 32'h00, 32'h77, 32'h00, "R5 zero divisor");
    runOp(2'b00, 32'h0, 32'h10, 32'hFFFF_FF00, "R5 zero after mask");
    runOp(2'b01, 32'h4000, 32'h1, 32'h4000, "R6 hi equal divisor");
    runOp(2'b01, 32'h9000, 32'h1, 32'h4000, "R6 hi above divisor");
    runOp(2'b00, 32'hABCD_EF12, 32'h5555_5534, 32'h7777_77F0, "R1 junk upper bits");
    runOp(2'b01, 32'hFFFF_0001, 32'hFFFF_2222, 32'h0000_0003, "R1 junk upper 16");
    runOp(2'b11, 32'h0123_4567, 32'h89AB_CDEF, 32'h0FED_CBA9, "R9 code 11");
    runOp(2'b10, 32'h0123_4567, 32'h89AB_CDEF, 32'h0FED_CBA9, "R9 code 10 ref");
    repeat (4) @(negedge clk);

    // R7: start held during a busy operation with other operands
    widthSel = 2'b01; dividendHi = 32'h0100; dividendLo = 32'h0203; divisor = 32'h0400;
    curTag = "R7 busy start ignored"; start = 1'b1;
    @(negedge clk);
    widthSel = 2'b00; dividendHi = 32'h1; dividendLo = 32'h2; divisor = 32'h0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (mBusy) @(negedge clk);
    // R7: back-to-back start at the edge after completion
    runOp(2'b00, 32'h3, 32'h9A, 32'h7, "R7 back-to-back");
    runOp(2'b10, 32'h5, 32'h6, 32'h7, "R7 back-to-back 2");

    for (int i = 0; i < 60; i++) begin
      logic [1:0]  ws;
      logic [31:0] msk, dv, hi, lo;
      int          w;
      ws  = 2'($urandom % 4);
      w   = widthOfSel(ws);
      msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      dv  = $urandom & msk;
      if (dv == 0) dv = 32'd1;
      hi  = $urandom % dv;
      lo  = $urandom;
      runOp(ws, hi | ($urandom & ~msk), lo, dv | ($urandom & ~msk), "R2 random");
    end
    repeat (3) @(negedge clk);
    report();
  end

endmodule